// File: doc/BRIEF.md
# SCSI Adapter DMA Control and Interrupt Gating

This block is the register and sequencing core of a SCSI bus adapter. It sits between a host register bus with 16-bit words and an 8-bit SCSI protocol controller. The host sees one word window of adapter registers and a second window that passes straight through to the controller. The adapter registers are a control/status word, a 32-bit DMA address, a 32-bit programmed transfer length, a 32-bit FIFO byte count, an interrupt vector/address-modifier word, a residual count and the FIFO fill level. Each 32-bit value is split into a high half and a low half.

The enable bit in the control word does two jobs. It starts the DMA engine, and it is also the only path by which the controller's interrupt reaches the interrupt output. To wait for reselection while idle, software clears the FIFO count and then sets enable. The engine then stays idle, and the controller interrupt can pass. While enable is set, host access to the controller window is refused. The FIFO is modelled by its fill level alone: bytes come in from the controller side under a request/acknowledge pair and go out on a memory-side take strobe.

Top module: `scsi_dma_gate`

## Requirements
- R1: After reset, every adapter register reads 0, scsi_rst_n and irq are low, ctrl_dack and ctrl_sel are low, and dma_addr is 0.
- R2: Control bits are active-low resets. Bit 0 low holds the FIFO level at 0 and refuses controller bytes. Bit 1 drives scsi_rst_n directly, so writing 0 to the control word holds both in reset.
- R3: The controller interrupt (ctrl_irq) reaches irq only while enable (control bit 2) is set.
- R4: The controller interrupt is kept off irq while the FIFO level is non-zero or the FIFO byte count is non-zero.
- R5: Status word index 0 reads bit 8 = raw controller interrupt, bit 9 = DMA interrupt pending, bit 10 = DMA conflict (set by mem_clash), bit 11 = DMA bus error (set by mem_err) and bit 12 = access conflict. Bit 9 reads 1 whenever either error flag is set. Status flags are sticky and are cleared by writing 1 to their bit. irq is high whenever bit 9 is high.
- R6: Index 1/2 hold DMA address high/low, index 3/4 hold transfer length high/low, and index 7 holds the vector/address-modifier word. All read back as written, and dma_addr shows {index1, index2}.
- R7: A controller byte request is acknowledged in the same cycle only when enable is set, FIFO reset is released, the FIFO count is non-zero and the level is below FIFO_DEPTH. Each acknowledged byte lowers the count (index 5/6) by one and raises the level (index 10) by one.
- R8: The completion flag behind status bit 9 sets when an acknowledged byte takes the FIFO count from 1 to 0.
- R9: With enable set and the FIFO count at zero, no byte is acknowledged and the engine stays idle.
- R10: Index 8/9 read the residual. In send mode (control bit 3 = 1), when the count is non-zero and below the programmed length, the residual is count + 1. Otherwise it equals the count.
- R11: While enable is set, a host access to the controller window (address bit 4 = 1) returns 0, raises no ctrl_sel and sets the access-conflict flag.
- R12: Writing the FIFO count low half (index 6) empties the FIFO level, and a host count write takes priority over a byte decrement in the same cycle.
- R13: mem_take lowers a non-zero level by one and is ignored at level 0. The level never exceeds FIFO_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host access strobe |
| hst_wr | input | 1 | Host write (1) or read (0) |
| hst_addr | input | ADDR_W | Word index; top bit selects the controller window |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data (combinational) |
| irq | output | 1 | Adapter interrupt request |
| scsi_rst_n | output | 1 | SCSI bus reset, active low |
| dma_send | output | 1 | Direction: 1 memory to SCSI |
| dma_addr | output | 32 | Programmed DMA address |
| ctrl_sel | output | 1 | Controller register strobe |
| ctrl_wr | output | 1 | Controller write strobe |
| ctrl_addr | output | 3 | Controller register index |
| ctrl_wdata | output | 8 | Controller write data |
| ctrl_rdata | input | 8 | Controller read data |
| ctrl_irq | input | 1 | Controller interrupt request |
| ctrl_drq | input | 1 | Controller byte request |
| ctrl_dack | output | 1 | Byte accepted into FIFO |
| mem_take | input | 1 | Memory side removes one byte |
| mem_err | input | 1 | Memory bus error pulse |
| mem_clash | input | 1 | DMA arbitration conflict pulse |

## Verification
A wrong count or level shows up in the same cycle as a wrong irq. A leftover level or count hides the controller interrupt, and a count stuck above zero keeps ctrl_dack asserted past the programmed length. A missed completion or error flag is visible one clock later on status bit 9 and on irq. A wrong enable state shows at once in two places: controller-window reads return 0 where they should not, or pass through where they should be blocked. The reference model checks irq, the acknowledge, the strobes and the read word after every edge, so a divergence is reported in the cycle it appears.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  // adapter window word indices
  localparam logic [3:0] IDX_CSR    = 4'd0;
  localparam logic [3:0] IDX_ADR_HI = 4'd1;
  localparam logic [3:0] IDX_ADR_LO = 4'd2;
  localparam logic [3:0] IDX_LEN_HI = 4'd3;
  localparam logic [3:0] IDX_LEN_LO = 4'd4;
  localparam logic [3:0] IDX_CNT_HI = 4'd5;
  localparam logic [3:0] IDX_CNT_LO = 4'd6;
  localparam logic [3:0] IDX_VECAM  = 4'd7;
  localparam logic [3:0] IDX_RES_HI = 4'd8;
  localparam logic [3:0] IDX_RES_LO = 4'd9;
  localparam logic [3:0] IDX_LEVEL  = 4'd10;

  localparam int NUM_HALVES = 4;
  localparam int NUM_FLAGS  = 4;
  localparam int FLAG_LSB   = 9;   // clear bits start here in the status word

  // flag slots: 0 completion, 1 conflict, 2 bus error, 3 access conflict
  localparam int FL_DONE  = 0;
  localparam int FL_CLASH = 1;
  localparam int FL_BERR  = 2;
  localparam int FL_ACC   = 3;

  typedef struct packed {
    logic send;
    logic en;
    logic srst_n;
    logic frst_n;
  } ctl_t;
endpackage

// File: rtl/sdg_fifo_track.sv
module sdg_fifo_track #(
  parameter int FIFO_DEPTH = 8192,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_hi,
  input  logic             ld_lo,
  input  logic [15:0]      wdata,
  input  logic             drq,
  input  logic             mem_take,
  input  logic             en,
  input  logic             frst_n,
  output logic [31:0]      fcnt,
  output logic [LVL_W-1:0] level,
  output logic             take,
  output logic             zero_hit
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(FIFO_DEPTH);

  logic [31:0]      fcnt_nx;
  logic             fcnt_ce;
  logic [LVL_W-1:0] level_nx;
  logic             inc, dec;

  always_comb begin
    take     = drq && en && frst_n && (fcnt != 32'd0) && (level != FULL);
    zero_hit = take && (fcnt == 32'd1);
    fcnt_ce  = ld_hi || ld_lo || take;
    if (ld_hi)       fcnt_nx = {wdata, fcnt[15:0]};
    else if (ld_lo)  fcnt_nx = {fcnt[31:16], wdata};
    else             fcnt_nx = fcnt - 32'd1;

    inc = take;
    dec = mem_take && (level != '0);
    if (!frst_n || ld_lo)  level_nx = '0;
    else if (inc && !dec)  level_nx = level + LVL_W'(1);
    else if (dec && !inc)  level_nx = level - LVL_W'(1);
    else                   level_nx = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fcnt <= '0;
    else if (fcnt_ce) fcnt <= fcnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= level_nx;
  end

  // R7
  take_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !ld_hi && !ld_lo |=> fcnt == $past(fcnt) - 32'd1);
  // R12
  lvl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> level == '0);
  // R13
  lvl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL);
endmodule

// File: rtl/sdg_regs.sv
module sdg_regs
  import scsi_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  idx,
  input  logic [15:0] wdata,
  input  logic        zero_hit,
  input  logic        mem_err,
  input  logic        mem_clash,
  input  logic        acc_hit,
  output ctl_t        ctl,
  output logic [31:0] dma_addr,
  output logic [31:0] xfer_len,
  output logic [15:0] vec_am,
  output logic [NUM_FLAGS-1:0] flags
);
  logic        csr_wr;
  ctl_t        ctl_nx;
  logic [15:0] half_q [NUM_HALVES];
  logic [NUM_FLAGS-1:0] fl_set, fl_clr;
  logic        vec_ld;

  always_comb begin
    csr_wr = wr_en && (idx == IDX_CSR);
    ctl_nx = csr_wr ? ctl_t'(wdata[3:0]) : ctl;
    vec_ld = wr_en && (idx == IDX_VECAM);
    fl_set = '0;
    fl_set[FL_DONE]  = zero_hit;
    fl_set[FL_CLASH] = mem_clash;
    fl_set[FL_BERR]  = mem_err;
    fl_set[FL_ACC]   = acc_hit;
    fl_clr = csr_wr ? wdata[FLAG_LSB +: NUM_FLAGS] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl <= '0;
    else if (csr_wr) ctl <= ctl_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_am <= '0;
    else if (vec_ld) vec_am <= wdata;
  end

  for (genvar k = 0; k < NUM_HALVES; k++) begin : g_half
    logic        ld;
    logic [15:0] q;
    assign ld = wr_en && (idx == 4'(k + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= wdata;
    end
    assign half_q[k] = q;
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    logic q, nx;
    assign nx = fl_set[f] || (q && !fl_clr[f]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nx;
    end
    assign flags[f] = q;
  end

  assign dma_addr = {half_q[0], half_q[1]};
  assign xfer_len = {half_q[2], half_q[3]};

  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> flags[FL_DONE]);
  // R5
  berr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_err |=> flags[FL_BERR]);
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr && wdata[FLAG_LSB + FL_CLASH] && !mem_clash |=> !flags[FL_CLASH]);
endmodule

// File: rtl/sdg_ctrl_gate.sv
module sdg_ctrl_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hst_sel,
  input  logic       hst_wr,
  input  logic       win,
  input  logic       en,
  input  logic [7:0] ctrl_rdata,
  input  logic       ctrl_irq,
  input  logic       fifo_empty,
  input  logic       fcnt_zero,
  input  logic       dma_ip,
  output logic       ctrl_sel,
  output logic       ctrl_wr,
  output logic [7:0] win_rdata,
  output logic       acc_hit,
  output logic       irq
);
  logic ctrl_pass;

  always_comb begin
    acc_hit   = hst_sel && win && en;
    ctrl_sel  = hst_sel && win && !en;
    ctrl_wr   = ctrl_sel && hst_wr;
    win_rdata = en ? 8'h00 : ctrl_rdata;
    ctrl_pass = en && ctrl_irq && fifo_empty && fcnt_zero;
    irq       = ctrl_pass || dma_ip;
  end

  // R11
  acc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> !ctrl_sel && !ctrl_wr && (win_rdata == 8'h00));
  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !dma_ip |-> !irq);
  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_empty || !fcnt_zero) && !dma_ip |-> !irq);
endmodule

// File: rtl/scsi_dma_gate.sv
module scsi_dma_gate
  import scsi_dma_pkg::*;
#(
  parameter int FIFO_DEPTH = 8192,
  parameter int ADDR_W     = 5,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_sel,
  input  logic              hst_wr,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [15:0]       hst_wdata,
  output logic [15:0]       hst_rdata,
  output logic              irq,
  output logic              scsi_rst_n,
  output logic              dma_send,
  output logic [31:0]       dma_addr,
  output logic              ctrl_sel,
  output logic              ctrl_wr,
  output logic [2:0]        ctrl_addr,
  output logic [7:0]        ctrl_wdata,
  input  logic [7:0]        ctrl_rdata,
  input  logic              ctrl_irq,
  input  logic              ctrl_drq,
  output logic              ctrl_dack,
  input  logic              mem_take,
  input  logic              mem_err,
  input  logic              mem_clash
);
  logic             win;
  logic [3:0]       idx;
  logic             a_wr;
  ctl_t             ctl;
  logic [31:0]      xfer_len, fcnt, resid;
  logic [15:0]      vec_am, csr_rd;
  logic [NUM_FLAGS-1:0] flags;
  logic [LVL_W-1:0] level;
  logic             take, zero_hit, acc_hit, dma_ip;
  logic [7:0]       win_rdata;

  assign win  = hst_addr[ADDR_W-1];
  assign idx  = hst_addr[3:0];
  assign a_wr = hst_sel && hst_wr && !win;

  sdg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(a_wr), .idx(idx), .wdata(hst_wdata),
    .zero_hit(zero_hit), .mem_err(mem_err), .mem_clash(mem_clash),
    .acc_hit(acc_hit), .ctl(ctl), .dma_addr(dma_addr), .xfer_len(xfer_len),
    .vec_am(vec_am), .flags(flags));

  sdg_fifo_track #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .ld_hi(a_wr && (idx == IDX_CNT_HI)), .ld_lo(a_wr && (idx == IDX_CNT_LO)),
    .wdata(hst_wdata), .drq(ctrl_drq), .mem_take(mem_take), .en(ctl.en),
    .frst_n(ctl.frst_n), .fcnt(fcnt), .level(level), .take(take),
    .zero_hit(zero_hit));

  sdg_ctrl_gate u_gate (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr), .win(win),
    .en(ctl.en), .ctrl_rdata(ctrl_rdata), .ctrl_irq(ctrl_irq),
    .fifo_empty(level == '0), .fcnt_zero(fcnt == 32'd0), .dma_ip(dma_ip),
    .ctrl_sel(ctrl_sel), .ctrl_wr(ctrl_wr), .win_rdata(win_rdata),
    .acc_hit(acc_hit), .irq(irq));

  always_comb begin
    dma_ip = flags[FL_DONE] || flags[FL_CLASH] || flags[FL_BERR];
    resid  = (ctl.send && (fcnt != 32'd0) && (fcnt < xfer_len)) ? fcnt + 32'd1 : fcnt;
    csr_rd = {3'b000, flags[FL_ACC], flags[FL_BERR], flags[FL_CLASH], dma_ip,
              ctrl_irq, 4'b0000, ctl};
    if (win) hst_rdata = {8'h00, win_rdata};
    else begin
      case (idx)
        IDX_CSR:    hst_rdata = csr_rd;
        IDX_ADR_HI: hst_rdata = dma_addr[31:16];
        IDX_ADR_LO: hst_rdata = dma_addr[15:0];
        IDX_LEN_HI: hst_rdata = xfer_len[31:16];
        IDX_LEN_LO: hst_rdata = xfer_len[15:0];
        IDX_CNT_HI: hst_rdata = fcnt[31:16];
        IDX_CNT_LO: hst_rdata = fcnt[15:0];
        IDX_VECAM:  hst_rdata = vec_am;
        IDX_RES_HI: hst_rdata = resid[31:16];
        IDX_RES_LO: hst_rdata = resid[15:0];
        IDX_LEVEL:  hst_rdata = 16'(level);
        default:    hst_rdata = 16'h0000;
      endcase
    end
  end

  assign scsi_rst_n = ctl.srst_n;
  assign dma_send   = ctl.send;
  assign ctrl_dack  = take;
  assign ctrl_addr  = hst_addr[2:0];
  assign ctrl_wdata = hst_wdata[7:0];

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt == 32'd0 |-> !ctrl_dack);
  // R2
  frst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.frst_n |=> level == '0);
endmodule

// File: tb/scsi_dma_gate_test.sv
module scsi_dma_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic sel, wr, c_irq, drq, mtake, merr, mclash;
  logic [4:0]  addr;
  logic [15:0] wdata;
  logic [7:0]  c_rd;
  logic [15:0] rdata;
  logic irq, srst, send, csel, cwr, dack;
  logic [31:0] daddr;
  logic [2:0]  caddr;
  logic [7:0]  cwd;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_dma_gate #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .hst_sel(sel), .hst_wr(wr), .hst_addr(addr),
    .hst_wdata(wdata), .hst_rdata(rdata), .irq(irq), .scsi_rst_n(srst),
    .dma_send(send), .dma_addr(daddr), .ctrl_sel(csel), .ctrl_wr(cwr),
    .ctrl_addr(caddr), .ctrl_wdata(cwd), .ctrl_rdata(c_rd), .ctrl_irq(c_irq),
    .ctrl_drq(drq), .ctrl_dack(dack), .mem_take(mtake), .mem_err(merr),
    .mem_clash(mclash));

  // behavioural reference state
  logic [3:0]  m_ctl;
  bit          m_done, m_clash, m_berr, m_acc;
  logic [15:0] m_half [4];
  logic [15:0] m_vec;
  logic [31:0] m_fcnt;
  int          m_lvl;
  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit finished = 0;

  function automatic bit exp_take();
    return drq && m_ctl[2] && m_ctl[0] && (m_fcnt != 0) && (m_lvl < DEPTH);
  endfunction

  function automatic bit exp_dip();
    return m_done || m_clash || m_berr;
  endfunction

  function automatic logic [31:0] exp_resid();
    logic [31:0] len;
    len = {m_half[2], m_half[3]};
    if (m_ctl[3] && m_fcnt != 0 && m_fcnt < len) return m_fcnt + 1;
    return m_fcnt;
  endfunction

  function automatic logic [15:0] exp_rd();
    if (addr[4]) return m_ctl[2] ? 16'h0 : {8'h0, c_rd};
    case (addr[3:0])
      4'd0:  return {3'b0, m_acc, m_berr, m_clash, exp_dip(), c_irq, 4'b0, m_ctl};
      4'd1, 4'd2, 4'd3, 4'd4: return m_half[addr[3:0] - 1];
      4'd5:  return m_fcnt[31:16];
      4'd6:  return m_fcnt[15:0];
      4'd7:  return m_vec;
      4'd8:  return exp_resid() >> 16;
      4'd9:  return exp_resid() & 32'hFFFF;
      4'd10: return 16'(m_lvl);
      default: return 16'h0;
    endcase
  endfunction

  task automatic cmp(string nm, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, nm, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctl = 0; m_done = 0; m_clash = 0; m_berr = 0; m_acc = 0;
    for (int i = 0; i < 4; i++) m_half[i] = 0;
    m_vec = 0; m_fcnt = 0; m_lvl = 0;
  endtask

  task automatic model_step();
    bit t, zh, ah, wa;
    logic [3:0] clr;
    int nl;
    t  = exp_take();
    zh = t && (m_fcnt == 1);
    ah = sel && addr[4] && m_ctl[2];
    wa = sel && wr && !addr[4];
    clr = (wa && addr[3:0] == 0) ? wdata[12:9] : 4'b0;
    nl = m_lvl + (t ? 1 : 0) - ((mtake && m_lvl > 0) ? 1 : 0);
    if (!m_ctl[0] || (wa && addr[3:0] == 6)) nl = 0;
    m_done  = zh     || (m_done  && !clr[0]);
    m_clash = mclash || (m_clash && !clr[1]);
    m_berr  = merr   || (m_berr  && !clr[2]);
    m_acc   = ah     || (m_acc   && !clr[3]);
    if (wa && addr[3:0] == 5)      m_fcnt[31:16] = wdata;
    else if (wa && addr[3:0] == 6) m_fcnt[15:0] = wdata;
    else if (t)                    m_fcnt = m_fcnt - 1;
    if (wa && addr[3:0] >= 1 && addr[3:0] <= 4) m_half[addr[3:0] - 1] = wdata;
    if (wa && addr[3:0] == 7) m_vec = wdata;
    if (wa && addr[3:0] == 0) m_ctl = wdata[3:0];
    m_lvl = nl;
  endtask

  task automatic tick();
    #1;
    cmp("irq", irq, (m_ctl[2] && c_irq && m_lvl == 0 && m_fcnt == 0) || exp_dip());
    cmp("scsi_rst_n", srst, m_ctl[1]);
    cmp("dma_send", send, m_ctl[3]);
    cmp("dma_addr", daddr, {m_half[0], m_half[1]});
    cmp("ctrl_sel", csel, sel && addr[4] && !m_ctl[2]);
    cmp("ctrl_wr", cwr, sel && wr && addr[4] && !m_ctl[2]);
    cmp("ctrl_addr", caddr, addr[2:0]);
    cmp("ctrl_wdata", cwd, wdata[7:0]);
    cmp("ctrl_dack", dack, exp_take());
    cmp("hst_rdata", rdata, exp_rd());
    @(posedge clk);
    if (!rst_n) model_reset(); else model_step();
    @(negedge clk);
  endtask

  task automatic wreg(input logic [4:0] a, input logic [15:0] d);
    sel = 1; wr = 1; addr = a; wdata = d; tick(); sel = 0; wr = 0;
  endtask

  task automatic rreg(input logic [4:0] a);
    addr = a; tick();
  endtask

  task automatic sweep();
    for (int i = 0; i <= 10; i++) rreg(5'(i));
  endtask

  initial begin
    rst_n = 0; sel = 0; wr = 0; addr = 0; wdata = 0; c_rd = 8'h5A;
    c_irq = 0; drq = 0; mtake = 0; merr = 0; mclash = 0;
    model_reset();
    @(negedge clk);
    cur_req = "R1";
    repeat (3) tick();
    rst_n = 1;
    sweep();

    cur_req = "R6";
    wreg(5'd1, 16'h00AB); wreg(5'd2, 16'hC0DE);
    wreg(5'd3, 16'h0000); wreg(5'd4, 16'd100); wreg(5'd7, 16'h3D44);
    sweep();

    cur_req = "R2";
    wreg(5'd0, 16'h0003); rreg(5'd0);

    cur_req = "R3";
    c_irq = 1; rreg(5'd0); rreg(5'd0);
    wreg(5'd0, 16'h0007); rreg(5'd0);

    cur_req = "R9";
    drq = 1; tick(); tick(); drq = 0;

    cur_req = "R4";
    wreg(5'd6, 16'd5); rreg(5'd6);
    cur_req = "R7";
    drq = 1; addr = 5'd10;
    for (int i = 0; i < 4; i++) tick();
    cur_req = "R8";
    tick(); tick(); drq = 0;
    rreg(5'd0);
    cur_req = "R4";
    wreg(5'd0, 16'h0207); rreg(5'd0); rreg(5'd10);
    cur_req = "R13";
    mtake = 1; addr = 5'd10;
    for (int i = 0; i < 6; i++) tick();
    mtake = 0; rreg(5'd0);

    cur_req = "R11";
    sel = 1; addr = 5'h13; tick(); wr = 1; tick(); sel = 0; wr = 0;
    rreg(5'd0);
    wreg(5'd0, 16'h1003);
    sel = 1; addr = 5'h15; tick(); wr = 1; wdata = 16'h0077; tick(); sel = 0; wr = 0;
    rreg(5'd0);

    cur_req = "R13";
    wreg(5'd6, 16'd20); wreg(5'd0, 16'h0007);
    drq = 1; addr = 5'd10;
    for (int i = 0; i < 20; i++) tick();
    drq = 0; rreg(5'd6);
    mtake = 1; drq = 1; tick(); tick(); mtake = 0; drq = 0; rreg(5'd10);

    cur_req = "R12";
    sel = 1; wr = 1; addr = 5'd6; wdata = 16'd3; drq = 1; tick();
    sel = 0; wr = 0; drq = 0; rreg(5'd10); rreg(5'd6);

    cur_req = "R2";
    drq = 1; tick(); drq = 0;
    wreg(5'd0, 16'h0006); drq = 1; addr = 5'd10; tick(); tick(); drq = 0;
    rreg(5'd6);
    wreg(5'd0, 16'h0000); rreg(5'd0);

    cur_req = "R10";
    wreg(5'd0, 16'h000B);
    wreg(5'd6, 16'd40); rreg(5'd8); rreg(5'd9);
    wreg(5'd6, 16'd100); rreg(5'd9);
    wreg(5'd6, 16'd0); rreg(5'd9);
    wreg(5'd0, 16'h0003); wreg(5'd6, 16'd40); rreg(5'd9);
    wreg(5'd6, 16'd0);

    cur_req = "R5";
    c_irq = 0;
    merr = 1; tick(); merr = 0; rreg(5'd0);
    mclash = 1; tick(); mclash = 0; rreg(5'd0);
    wreg(5'd0, 16'h0803); rreg(5'd0);
    wreg(5'd0, 16'h1603); rreg(5'd0);
    sel = 1; wr = 0; addr = 5'd0; mclash = 1; wdata = 16'h0403;
    tick(); sel = 0; mclash = 0; rreg(5'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule